// File: doc/BRIEF.md
# Externally Strobed DAC Update Logic

This block sits between the bus-written data registers of a set of DAC channels and the latches that feed the converters. Each channel has its own mode bit. With the bit clear, a bus write to the channel goes straight to its output latch. With the bit set, the written value waits in a holding register. The output latch is loaded from it while an active-low external update pin is held low.

The external load is level-sensitive rather than edge-triggered. While the pin stays low, the latch of an externally loaded channel stays transparent, so a write made during that window reaches the output on the next clock. A rising edge on the same pin raises a sticky interrupt request when interrupts are enabled. Software can then refill the holding registers between strobes, which gives externally timed, interrupt-driven waveform output.

The pin is asynchronous, so it passes through a two-flop synchronizer before its level or its edges are used. All outputs are registered. Reset is synchronous and active-high.

Top module: `ext_dac_update`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows every channel code at zero and the interrupt request low.
- R2: A channel whose external-load bit is 0 shows the data written to it one cycle after the write strobe.
- R3: A channel whose external-load bit is 1 keeps its output unchanged while the synchronized pin level is high, whatever is written to it.
- R4: A channel whose external-load bit is 1 loads its holding register (the last value written) into its output while the synchronized pin level is low.
- R5: While the synchronized pin level is low, a write to an externally loaded channel reaches that channel's output one cycle after the strobe.
- R6: Channels are independent. Channel c occupies bits [c*DATA_W +: DATA_W] of `dac_code` and changes only through its own write strobe bit c and mode bit c.
- R7: With `irq_en` high, a rising edge of the synchronized pin sets `irq` on the following cycle.
- R8: With `irq_en` low, edges of the pin never set `irq`.
- R9: `irq` stays high until a cycle with `irq_clr` high clears it. A rising edge detected in the same cycle as the clear keeps it high.
- R10: A change of the pin takes effect on the outputs at the third clock edge after it is applied: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_CH | Per-channel bus write strobe |
| wr_data | input | DATA_W | Bus write data shared by all channels |
| ext_mode | input | NUM_CH | Per-channel external-load select, 1 = loaded by the pin |
| irq_en | input | 1 | Interrupt enable for pin rising edges |
| upd_n_pin | input | 1 | Asynchronous active-low external update pin |
| irq_clr | input | 1 | Clears the interrupt request |
| dac_code | output | NUM_CH*DATA_W | Latched output codes, channel c at [c*DATA_W +: DATA_W] |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with its defaults: two channels, 12-bit codes and two synchronizer stages. With these values, full-scale codes and every combination of the two mode bits can be reached. Directed sequences hit the synchronizer latency, the transparent window with the pin held low, and a clear that coincides with an edge. A seeded random phase then toggles the pin, the modes and the strobes against a cycle model kept in the bench.

// File: rtl/dacupd_pkg.sv
package dacupd_pkg;
  // Source chosen for an output latch in a given cycle
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_BUS  = 2'd1,
    LD_HOLD = 2'd2
  } load_sel_e;
endpackage

// File: rtl/dacupd_sync.sv
module dacupd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic level,
  output logic rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], pin_async};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/dacupd_chan.sv
module dacupd_chan
  import dacupd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_mode,
  input  logic              pin_lvl,
  output logic [DATA_W-1:0] code
);
  logic [DATA_W-1:0] hold_q;
  load_sel_e         sel;

  always_comb begin
    sel = LD_NONE;
    if (!ext_mode) begin
      if (wr_en) sel = LD_BUS;
    end else if (!pin_lvl) begin
      sel = wr_en ? LD_BUS : LD_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      code   <= '0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      case (sel)
        LD_BUS:  code <= wr_data;
        LD_HOLD: code <= hold_q;
        default: code <= code;
      endcase
    end
  end
endmodule

// File: rtl/dacupd_irq.sv
module dacupd_irq (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic edge_seen,
  input  logic irq_clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (irq & ~irq_clr) | (edge_seen & irq_en);
  end
endmodule

// File: rtl/ext_dac_update.sv
module ext_dac_update #(
  parameter int DATA_W      = 12,
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]        ext_mode,
  input  logic                     irq_en,
  input  logic                     upd_n_pin,
  input  logic                     irq_clr,
  output logic [NUM_CH*DATA_W-1:0] dac_code,
  output logic                     irq
);
  logic pin_lvl;
  logic pin_rise;

  dacupd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (upd_n_pin),
    .level     (pin_lvl),
    .rise      (pin_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dacupd_chan #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en[c]),
      .wr_data  (wr_data),
      .ext_mode (ext_mode[c]),
      .pin_lvl  (pin_lvl),
      .code     (dac_code[c*DATA_W +: DATA_W])
    );
  end

  dacupd_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .irq_en    (irq_en),
    .edge_seen (pin_rise),
    .irq_clr   (irq_clr),
    .irq       (irq)
  );
endmodule

// File: rtl/ext_dac_update_chk.sv
module ext_dac_update_chk #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH-1:0]        wr_en,
  input logic [DATA_W-1:0]        wr_data,
  input logic [NUM_CH-1:0]        ext_mode,
  input logic                     irq_en,
  input logic                     irq_clr,
  input logic                     pin_lvl,
  input logic                     pin_rise,
  input logic [NUM_CH*DATA_W-1:0] dac_code,
  input logic                     irq
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && dac_code == '0));

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_rise && irq_en) |=> irq);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && !(pin_rise && irq_en)) |=> !irq);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en[c] && !ext_mode[c]) |=>
        dac_code[c*DATA_W +: DATA_W] == $past(wr_data));

    // R3
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ext_mode[c] && pin_lvl) |=> $stable(dac_code[c*DATA_W +: DATA_W]));

    // R5
    ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (ext_mode[c] && !pin_lvl && wr_en[c]) |=>
        dac_code[c*DATA_W +: DATA_W] == $past(wr_data));
  end
endmodule

bind ext_dac_update ext_dac_update_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .ext_mode (ext_mode),
  .irq_en   (irq_en),
  .irq_clr  (irq_clr),
  .pin_lvl  (pin_lvl),
  .pin_rise (pin_rise),
  .dac_code (dac_code),
  .irq      (irq)
);

// File: tb/ext_dac_update_bench.sv
module ext_dac_update_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int NUM_CH = 2;

  logic                     clk = 1'b0;
  logic                     rst;
  logic [NUM_CH-1:0]        wr_en;
  logic [DATA_W-1:0]        wr_data;
  logic [NUM_CH-1:0]        ext_mode;
  logic                     irq_en;
  logic                     upd_n_pin;
  logic                     irq_clr;
  logic [NUM_CH*DATA_W-1:0] dac_code;
  logic                     irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [DATA_W-1:0] m_hold [NUM_CH];
  logic [DATA_W-1:0] m_out  [NUM_CH];
  logic [2:0]        m_pin;   // [0],[1] synchronizer stages, [2] previous level
  logic              m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_dac_update #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .SYNC_STAGES(2)) u_ext_dac_update (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ext_mode(ext_mode),
    .irq_en(irq_en), .upd_n_pin(upd_n_pin), .irq_clr(irq_clr),
    .dac_code(dac_code), .irq(irq)
  );

  function automatic logic [DATA_W-1:0] next_code(logic mode, logic lvl, logic we,
                                                  logic [DATA_W-1:0] d,
                                                  logic [DATA_W-1:0] hold,
                                                  logic [DATA_W-1:0] cur);
    if (!mode) return we ? d : cur;
    if (!lvl)  return we ? d : hold;
    return cur;
  endfunction

  task automatic model_step();
    logic lvl, rise;
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin m_hold[c] = '0; m_out[c] = '0; end
      m_pin = 3'b111;
      m_irq = 1'b0;
    end else begin
      lvl  = m_pin[1];
      rise = m_pin[1] & ~m_pin[2];
      for (int c = 0; c < NUM_CH; c++) begin
        m_out[c] = next_code(ext_mode[c], lvl, wr_en[c], wr_data, m_hold[c], m_out[c]);
        if (wr_en[c]) m_hold[c] = wr_data;
      end
      m_irq = (m_irq & ~irq_clr) | (rise & irq_en);
      m_pin = {m_pin[1:0], upd_n_pin};
    end
  endtask

  task automatic check(string req);
    for (int c = 0; c < NUM_CH; c++) begin
      checks++;
      if (dac_code[c*DATA_W +: DATA_W] !== m_out[c]) begin
        errors++;
        $display("FAIL %s ch%0d code: actual %h expected %h", req, c,
                 dac_code[c*DATA_W +: DATA_W], m_out[c]);
      end
    end
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", req, irq, m_irq);
    end
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    @(negedge clk);
    model_step();
    check(req);
  endtask

  task automatic expect_code(string req, int c, logic [DATA_W-1:0] v);
    checks++;
    if (dac_code[c*DATA_W +: DATA_W] !== v) begin
      errors++;
      $display("FAIL %s ch%0d direct: actual %h expected %h", req, c,
               dac_code[c*DATA_W +: DATA_W], v);
    end
  endtask

  task automatic expect_irq(string req, logic v);
    checks++;
    if (irq !== v) begin
      errors++;
      $display("FAIL %s irq direct: actual %b expected %b", req, irq, v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst = 1'b1; wr_en = '0; wr_data = '0; ext_mode = '0;
    irq_en = 1'b0; upd_n_pin = 1'b1; irq_clr = 1'b0;
    @(negedge clk);
    repeat (3) cycle("R1");
    expect_code("R1", 0, '0); expect_code("R1", 1, '0); expect_irq("R1", 1'b0);
    rst = 1'b0;

    // R2 / R6: immediate write on ch0, ch1 untouched
    wr_en = 2'b01; wr_data = 12'hABC; cycle("R2");
    expect_code("R2", 0, 12'hABC); expect_code("R6", 1, 12'h000);
    wr_en = '0; cycle("R6");

    // R3: external mode, pin high, write is held back
    ext_mode = 2'b11; wr_en = 2'b10; wr_data = 12'h123; cycle("R3");
    wr_en = '0; cycle("R3");
    expect_code("R3", 1, 12'h000);

    // R10 / R4: pin low takes effect at the third edge
    upd_n_pin = 1'b0;
    cycle("R10"); expect_code("R10", 1, 12'h000);
    cycle("R10"); expect_code("R10", 1, 12'h000);
    cycle("R4");  expect_code("R4", 1, 12'h123);
    expect_code("R4", 0, 12'hABC);

    // R5: write while low passes through
    wr_en = 2'b01; wr_data = 12'hFFF; cycle("R5");
    expect_code("R5", 0, 12'hFFF);
    wr_en = '0; cycle("R5");

    // R7: rising edge with interrupts enabled
    irq_en = 1'b1; upd_n_pin = 1'b1;
    cycle("R7"); cycle("R7"); expect_irq("R7", 1'b0);
    cycle("R7"); expect_irq("R7", 1'b1);
    // R9: sticky
    repeat (3) cycle("R9");
    expect_irq("R9", 1'b1);
    // R9: clear coinciding with a new edge keeps irq set
    upd_n_pin = 1'b0; repeat (3) cycle("R9");
    upd_n_pin = 1'b1; cycle("R9"); cycle("R9");
    irq_clr = 1'b1; cycle("R9"); expect_irq("R9", 1'b1);
    cycle("R9"); expect_irq("R9", 1'b0);
    irq_clr = 1'b0;

    // R8: edges ignored when disabled
    irq_en = 1'b0;
    upd_n_pin = 1'b0; repeat (3) cycle("R8");
    upd_n_pin = 1'b1; repeat (4) cycle("R8");
    expect_irq("R8", 1'b0);

    // R4 random mix
    for (int i = 0; i < 3000; i++) begin
      wr_en     = 2'($urandom_range(0, 3));
      wr_data   = 12'($urandom);
      if ($urandom_range(0, 15) == 0) ext_mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) upd_n_pin = ~upd_n_pin;
      irq_en    = ($urandom_range(0, 3) != 0);
      irq_clr   = ($urandom_range(0, 7) == 0);
      cycle("R4");
    end

    // R1: reset mid-run
    rst = 1'b1; cycle("R1");
    expect_code("R1", 0, '0); expect_irq("R1", 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule